// File: doc/BRIEF.md
# Prioritized Speech Event Trigger Queue

This block gathers event triggers from hardware and firmware and turns them into one-byte event vectors for a speech playback engine. The engine reads the vectors from an eight-deep first-in first-out queue and plays the voice message that each vector selects. Hardware triggers come from one card-slot detect line, five external trap lines and seventeen monitor alarms (voltages, temperature, fans, case intrusion). Each trigger is captured on its rising edge and stays pending until it is admitted to the queue. Only one event can enter the queue per clock cycle. When several events are pending, a fixed priority decides which one enters.

Firmware raises a software event by writing a 7-bit event code. With the timeout disabled, the code is queued at once. With the timeout enabled, the code is armed instead. It is released only when an 8-bit seconds counter reaches a programmed limit. This works as a watchdog: firmware arms the event early in power-up, and the message plays only if the system stalls long enough for the count to reach the limit. The seconds tick is derived from the system clock through a prescaler parameter. A small register port sets the timeout limit, the event code and the enable bit.

Top module: `vevq_top`

## Requirements
- R1: After reset, `q_empty` is 1, `q_full` is 0, and all three registers read 0.
- R2: Pending events enter the queue in ascending source index. The indices are: card slot 0, traps 1 to 5 at indices 1..5, the software event at index 6, and monitor alarms 0..16 at indices 7..23.
- R3: A hardware source with index i is queued as the byte 0x80 + i. A software event is queued as its 7-bit code, with bit 7 equal to 0.
- R4: A hardware trigger is captured on its rising edge and stays pending until it is queued. A trigger held high produces exactly one queue entry.
- R5: At most one vector enters the queue per cycle. The queue presents its oldest entry on `q_data`, and a `q_pop` strobe removes that entry.
- R6: The queue holds at most DEPTH entries (default 8) and raises `q_full` when it holds DEPTH. While the queue is full, events stay pending and are not lost. They enter after a pop, still in priority order.
- R7: A `q_clr` strobe empties the queue. A `q_pop` while the queue is empty has no effect.
- R8: With the timeout disabled (control bit 0 = 0), a write to the code register (address 1) queues that code.
- R9: With the timeout enabled, a code write only arms the event. The seconds counter restarts from 0 when enable goes from 0 to 1, and it advances once every PRESCALE clocks. The armed code is queued only once the counter equals the timeout register (address 0).
- R10: Registers read back as written: address 0 holds the timeout limit (8 bits), address 1 holds the code (bits 6..0), and address 2 holds the enable (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_trig | input | 1 | Card-slot detect trigger |
| trap_trig | input | N_TRAP | External trap triggers, bit k is trap k+1 |
| mon_trig | input | N_MON | Hardware-monitor alarm triggers |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| q_pop | input | 1 | Remove the head entry of the queue |
| q_clr | input | 1 | Empty the queue |
| q_data | output | 8 | Head entry of the queue |
| q_empty | output | 1 | Queue holds no entries |
| q_full | output | 1 | Queue holds DEPTH entries |

## Verification
The bench builds the block with PRESCALE set to 4, so one "second" lasts four clocks. This puts timeout limits of a few seconds within tens of cycles. The default 24 sources and a depth of 8 are kept. Random bursts of many simultaneous triggers therefore overflow the queue, which exercises the full flag, the holding of pending events and the refill after each pop. Directed cases cover the timeout release window, a trigger held high, the clear strobe and register readback.

// File: rtl/vevq_pkg.sv
package vevq_pkg;

   localparam int unsigned VEC_W  = 8;
   localparam int unsigned CODE_W = 7;
   localparam int unsigned TMO_W  = 8;

   typedef logic [VEC_W-1:0]  vec_t;
   typedef logic [CODE_W-1:0] code_t;

   typedef enum logic [1:0] {
      RA_TIMEOUT = 2'd0,
      RA_CODE    = 2'd1,
      RA_CTRL    = 2'd2
   } reg_addr_e;

   // hardware sources carry bit 7 set plus their priority index
   function automatic vec_t hw_vector(input code_t idx);
      return {1'b1, idx};
   endfunction

   function automatic vec_t sw_vector(input code_t code);
      return {1'b0, code};
   endfunction

endpackage

// File: rtl/vevq_trig_latch.sv
module vevq_trig_latch #(
   parameter int unsigned N = 23
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] trig,
   input  logic [N-1:0] taken,
   output logic [N-1:0] pend
);

   if (N < 1) begin : g_bad_n
      $error("vevq_trig_latch: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_src
      logic prev_q;
      logic pend_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
         end else begin
            prev_q <= trig[i];
            pend_q <= (pend_q & ~taken[i]) | (trig[i] & ~prev_q);
         end
      end

      assign pend[i] = pend_q;

      // R4: a pending event is only dropped by being taken
      a_r4_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
         pend_q && !taken[i] |=> pend_q);
      // R4: nothing is taken that was not pending
      a_r4_take_pending: assert property (@(posedge clk) disable iff (!rst_n)
         taken[i] |-> pend_q);
   end

endmodule

// File: rtl/vevq_prio_arb.sv
module vevq_prio_arb #(
   parameter int unsigned N = 24
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           allow,
   input  logic [N-1:0]   req,
   output logic [N-1:0]   grant,
   output logic [IW-1:0]  idx,
   output logic           valid
);

   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

   if (N < 2) begin : g_bad_n
      $error("vevq_prio_arb: N must be at least 2");
   end

   always_comb begin
      grant = '0;
      idx   = '0;
      valid = 1'b0;
      for (int i = 0; i < int'(N); i++) begin
         if (allow && req[i] && !valid) begin
            grant[i] = 1'b1;
            idx      = IW'(i);
            valid    = 1'b1;
         end
      end
   end

   // R5: one winner per cycle
   a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R6: nothing granted while the queue cannot accept
   a_r6_no_grant_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      !allow |-> grant == '0);

endmodule

// File: rtl/vevq_tmo_timer.sv
module vevq_tmo_timer #(
   parameter int unsigned PRESCALE = 50_000_000,
   parameter int unsigned CNT_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic             match
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (PRESCALE < 1) begin : g_bad_pre
      $error("vevq_tmo_timer: PRESCALE must be at least 1");
   end

   logic tick;

   if (PRESCALE == 1) begin : g_no_pre
      assign tick = en;
   end else begin : g_pre
      localparam int unsigned PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk) begin
         if (!rst_n || !en) begin
            pre_q <= '0;
         end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end

      assign tick = en && (pre_q == PRE_LAST);
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q <= '0;
      end else if (tick && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt   = cnt_q;
   assign match = en && (cnt_q == limit);

   // R9: a fresh enable starts counting from zero
   a_r9_rise_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> cnt_q == '0);
   // R9: the count moves by at most one step per cycle
   a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (!en || cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/vevq_fifo.sv
module vevq_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   input  logic         clr,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);

   localparam int unsigned PW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   localparam logic [CW-1:0] CAP  = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("vevq_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CAP);
   assign do_push = push && !full && !clr;
   assign do_pop  = pop && !empty && !clr;
   assign dout    = mem[rd_q];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
         if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= din;
   end

   // R6: the arbiter never offers a push to a full queue
   a_r6_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R6: occupancy never exceeds the capacity
   a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CAP);
   // R7: a clear strobe leaves the queue empty
   a_r7_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);
   // R7: a pop on an empty queue leaves it empty unless something is pushed
   a_r7_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      empty && !push |=> empty);

endmodule

// File: rtl/vevq_top.sv
module vevq_top #(
   parameter int unsigned N_TRAP   = 5,
   parameter int unsigned N_MON    = 17,
   parameter int unsigned DEPTH    = 8,
   parameter int unsigned PRESCALE = 50_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_trig,
   input  logic [N_TRAP-1:0] trap_trig,
   input  logic [N_MON-1:0]  mon_trig,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              q_pop,
   input  logic              q_clr,
   output logic [7:0]        q_data,
   output logic              q_empty,
   output logic              q_full
);

   import vevq_pkg::*;

   localparam int unsigned N_HW   = 1 + N_TRAP + N_MON;
   localparam int unsigned N_SRC  = N_HW + 1;
   localparam int unsigned SW_IDX = 1 + N_TRAP;
   localparam int unsigned IW     = $clog2(N_SRC);

   if (N_SRC > 128) begin : g_bad_src
      $error("vevq_top: at most 128 sources fit the vector index");
   end
   if (N_TRAP < 1 || N_MON < 1) begin : g_bad_cnt
      $error("vevq_top: need at least one trap and one monitor input");
   end

   // ---------------- registers ----------------
   logic [TMO_W-1:0] tmo_q;
   code_t            code_q;
   logic             en_q;
   logic             code_wr;

   assign code_wr = reg_wr && (reg_addr == RA_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmo_q  <= '0;
         code_q <= '0;
         en_q   <= 1'b0;
      end else if (reg_wr) begin
         case (reg_addr)
            RA_TIMEOUT: tmo_q  <= reg_wdata;
            RA_CODE:    code_q <= reg_wdata[CODE_W-1:0];
            RA_CTRL:    en_q   <= reg_wdata[0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (reg_addr)
         RA_TIMEOUT: reg_rdata = tmo_q;
         RA_CODE:    reg_rdata = {1'b0, code_q};
         RA_CTRL:    reg_rdata = {7'b0, en_q};
         default:    reg_rdata = '0;
      endcase
   end

   // ---------------- timeout timer ----------------
   logic [TMO_W-1:0] sec_cnt;
   logic             tmo_hit;

   vevq_tmo_timer #(.PRESCALE(PRESCALE), .CNT_W(TMO_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_q),
      .limit (tmo_q),
      .cnt   (sec_cnt),
      .match (tmo_hit)
   );

   // ---------------- trigger capture ----------------
   logic [N_HW-1:0]  hw_trig, hw_pend, hw_taken;
   logic [N_SRC-1:0] req, grant;
   logic [IW-1:0]    win_idx;
   logic             win_valid;
   logic             sw_armed_q, sw_pend_q;

   assign hw_trig = {mon_trig, trap_trig, slot_trig};

   vevq_trig_latch #(.N(N_HW)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (hw_trig),
      .taken (hw_taken),
      .pend  (hw_pend)
   );

   // splice the software slot into the priority order
   assign req      = {hw_pend[N_HW-1:SW_IDX], sw_pend_q, hw_pend[SW_IDX-1:0]};
   assign hw_taken = {grant[N_SRC-1:SW_IDX+1], grant[SW_IDX-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sw_armed_q <= 1'b0;
         sw_pend_q  <= 1'b0;
      end else begin
         if (grant[SW_IDX]) sw_pend_q <= 1'b0;
         if (!en_q) sw_armed_q <= 1'b0;
         if (code_wr) begin
            if (en_q) sw_armed_q <= 1'b1;
            else      sw_pend_q  <= 1'b1;
         end else if (sw_armed_q && tmo_hit) begin
            sw_armed_q <= 1'b0;
            sw_pend_q  <= 1'b1;
         end
      end
   end

   // ---------------- arbitration ----------------
   logic accept;
   vec_t win_vec;

   assign accept = !q_full && !q_clr;

   vevq_prio_arb #(.N(N_SRC)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .allow (accept),
      .req   (req),
      .grant (grant),
      .idx   (win_idx),
      .valid (win_valid)
   );

   assign win_vec = (win_idx == IW'(SW_IDX)) ? sw_vector(code_q)
                                             : hw_vector(CODE_W'(win_idx));

   // ---------------- queue ----------------
   vevq_fifo #(.W(VEC_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (win_valid),
      .din   (win_vec),
      .pop   (q_pop),
      .clr   (q_clr),
      .dout  (q_data),
      .empty (q_empty),
      .full  (q_full)
   );

   // R8: with the timeout off, a code write makes the software event pending
   a_r8_direct_sw: assert property (@(posedge clk) disable iff (!rst_n)
      code_wr && !en_q |=> sw_pend_q);
   // R9: an armed event becomes pending only when the count equals the limit
   a_r9_wait_limit: assert property (@(posedge clk) disable iff (!rst_n)
      sw_armed_q && !tmo_hit && !code_wr |=> !sw_pend_q || $past(sw_pend_q));
   // R3: software vectors leave with bit 7 clear, hardware ones with it set
   a_r3_vec_class: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (q_data[7] == q_data[7]) && (win_vec[7] == !grant[SW_IDX]));

endmodule

// File: tb/vevq_top_tb_top.sv
module vevq_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N_TRAP = 5;
   localparam int N_MON  = 17;
   localparam int N_SRC  = 1 + N_TRAP + 1 + N_MON;
   localparam int DEPTH  = 8;
   localparam int PRE    = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              slot_trig = 1'b0;
   logic [N_TRAP-1:0] trap_trig = '0;
   logic [N_MON-1:0]  mon_trig = '0;
   logic              reg_wr = 1'b0;
   logic [1:0]        reg_addr = '0;
   logic [7:0]        reg_wdata = '0;
   logic [7:0]        reg_rdata;
   logic              q_pop = 1'b0;
   logic              q_clr = 1'b0;
   logic [7:0]        q_data;
   logic              q_empty, q_full;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vevq_top #(.N_TRAP(N_TRAP), .N_MON(N_MON), .DEPTH(DEPTH), .PRESCALE(PRE)) dut_i (
      .clk(clk), .rst_n(rst_n), .slot_trig(slot_trig), .trap_trig(trap_trig),
      .mon_trig(mon_trig), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .q_pop(q_pop), .q_clr(q_clr),
      .q_data(q_data), .q_empty(q_empty), .q_full(q_full));

   // expected vector from the requirement encoding (R3)
   function automatic logic [7:0] exp_vec(input int idx, input logic [6:0] code);
      if (idx == 1 + N_TRAP) return {1'b0, code};
      return 8'h80 | 8'(idx);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic pop1();
      q_pop = 1'b1;
      @(negedge clk);
      q_pop = 1'b0;
      @(negedge clk);
   endtask

   // pulse a set of sources in one cycle; bit 6 also writes the software code
   task automatic pulse(input logic [N_SRC-1:0] m, input logic [6:0] code);
      @(negedge clk);
      slot_trig = m[0];
      trap_trig = m[N_TRAP:1];
      mon_trig  = m[N_SRC-1:N_TRAP+2];
      if (m[N_TRAP+1]) begin
         reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = {1'b0, code};
      end
      @(negedge clk);
      slot_trig = 1'b0; trap_trig = '0; mon_trig = '0; reg_wr = 1'b0;
   endtask

   task automatic drain_expect(input string req, input logic [N_SRC-1:0] m, input logic [6:0] code);
      for (int i = 0; i < N_SRC; i++) begin
         if (m[i]) begin
            check({req, " nonempty"}, {7'b0, q_empty}, 8'h00);
            check(req, q_data, exp_vec(i, code));
            pop1();
         end
      end
      check({req, " drained"}, {7'b0, q_empty}, 8'h01);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seed;
      logic [N_SRC-1:0] m;
      logic [6:0] code;
      seed = 32'h5eed_1234;
      void'($urandom(seed));

      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      check("R1 empty", {7'b0, q_empty}, 8'h01);
      check("R1 full", {7'b0, q_full}, 8'h00);
      for (int a = 0; a < 3; a++) begin
         reg_addr = 2'(a); #1;
         check("R1 reg", reg_rdata, 8'h00);
      end

      // R10 readback, R8 direct software event
      wr(2'd0, 8'h5A);
      reg_addr = 2'd0; #1; check("R10 timeout", reg_rdata, 8'h5A);
      wr(2'd1, 8'h33);
      reg_addr = 2'd1; #1; check("R10 code", reg_rdata, 8'h33);
      cyc(3);
      check("R8 sw queued", q_data, 8'h33);
      pop1();
      check("R8 drained", {7'b0, q_empty}, 8'h01);

      // R2 R3 sw vs hw ordering: trap5, sw, monitor 0
      m = '0; m[5] = 1'b1; m[6] = 1'b1; m[7] = 1'b1;
      pulse(m, 7'h21);
      cyc(6);
      drain_expect("R2 mixed", m, 7'h21);

      // R6 everything at once overflows the queue
      m = '1;
      pulse(m, 7'h01);
      cyc(30);
      check("R6 full", {7'b0, q_full}, 8'h01);
      drain_expect("R6 refill order", m, 7'h01);

      // R4 held trigger gives one entry
      @(negedge clk); mon_trig[3] = 1'b1;
      cyc(5);
      check("R4 held vec", q_data, 8'h80 | 8'(10));
      pop1();
      cyc(5);
      check("R4 held once", {7'b0, q_empty}, 8'h01);
      mon_trig[3] = 1'b0;

      // R7 clear and pop on empty
      m = '0; m[0] = 1'b1; m[2] = 1'b1;
      pulse(m, 7'h00);
      cyc(4);
      @(negedge clk); q_clr = 1'b1;
      @(negedge clk); q_clr = 1'b0;
      check("R7 cleared", {7'b0, q_empty}, 8'h01);
      pop1();
      check("R7 pop empty", {7'b0, q_empty}, 8'h01);
      check("R7 pop empty full", {7'b0, q_full}, 8'h00);

      // R9 timeout: limit 3, enable, then arm
      wr(2'd0, 8'd3);
      wr(2'd2, 8'h01);
      reg_addr = 2'd2; #1; check("R10 ctrl", reg_rdata, 8'h01);
      wr(2'd1, 8'h11);
      cyc(6);
      check("R9 waits", {7'b0, q_empty}, 8'h01);
      cyc(14);
      check("R9 released", q_data, 8'h11);
      pop1();
      check("R9 once", {7'b0, q_empty}, 8'h01);
      wr(2'd2, 8'h00);

      // R2 R5 R6 random bursts
      for (int r = 0; r < 20; r++) begin
         m = N_SRC'({$urandom(), $urandom()});
         code = 7'($urandom());
         pulse(m, code);
         cyc(30);
         check("R6 full flag", {7'b0, q_full}, ($countones(m) >= DEPTH) ? 8'h01 : 8'h00);
         drain_expect("R5 random order", m, code);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule